// File: doc/BRIEF.md
# Camera Pixel Capture and Formatter

This block sits on the parallel output port of an image sensor and turns its byte stream into whole pixels. It runs in the sensor's pixel clock domain and samples the 8-bit data bus on each rising clock edge, but only while the line-active input is high. Each pair of bytes within a line forms one pixel. The block presents that pixel together with its column and line position and a one-cycle valid strobe, so a downstream address generator can place it in a frame store.

A frame begins when the frame-sync input goes from high to low. At that point the position counters clear and a one-cycle frame-start pulse is raised. Each rising edge of the line-active input opens a new line. A mode input picks the output format. In colour mode the two bytes are joined into a 16-bit RGB565 word. In grayscale mode the stream is treated as YUYV, and only the leading luminance byte of each pair is kept as an 8-bit gray level.

Top module: `cam_pixel_capture`

## Requirements
- R1: While `rst_n` is low, and on the first clock after its release, `pix_valid` and `frame_start` are 0 and `pix_data`, `pix_col` and `pix_line` are all zero.
- R2: When `vsync` is sampled 1 on one rising `pclk` edge and 0 on the next, `frame_start` is 1 for exactly the following cycle. In that same cycle `pix_col` and `pix_line` read 0.
- R3: Each sampled rising edge of `href` starts a new line. The first line after a frame start has `pix_line` 0, and each later line in the frame has a value one higher than the line before it.
- R4: Bytes are taken only on `pclk` edges where `href` is 1. Bus activity while `href` is 0 produces no `pix_valid` and changes no output.
- R5: The byte phase returns to "first byte" on every rising edge of `href`. A line that ends after an odd byte drops that byte. The first byte of the next line always opens a new pair.
- R6: With `gray_mode` = 0, `pix_data` = {first byte, second byte}. The first byte holds red[4:0] in bits 7..3 and green[5:3] in bits 2..0. The second byte holds green[2:0] in bits 7..5 and blue[4:0] in bits 4..0. The result is therefore red in `pix_data`[15:11], green in [10:5] and blue in [4:0].
- R7: With `gray_mode` = 1, `pix_data` = {8'h00, first byte of the pair}, and the second (chroma) byte is discarded. The mode is taken on the edge that samples the second byte.
- R8: `pix_valid` is 1 for exactly one cycle: the cycle after the edge that sampled the second byte of a pair. It is never high on two consecutive cycles.
- R9: `pix_col` shows the column of the pixel being presented. It is 0 for the first pixel of each line and rises by one for each later pixel in that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Sensor pixel clock; all sampling is on its rising edge |
| rst_n | input | 1 | Active-low reset |
| vsync | input | 1 | Frame sync; a high-to-low transition begins a frame |
| href | input | 1 | Line active; bytes are valid while high |
| din | input | 8 | Sensor data byte |
| gray_mode | input | 1 | 1 = keep Y byte of YUYV, 0 = pack RGB565 |
| pix_data | output | 16 | Assembled pixel value |
| pix_col | output | COL_W (10) | Column of the presented pixel |
| pix_line | output | LINE_W (9) | Line of the presented pixel |
| pix_valid | output | 1 | One-cycle strobe marking a new pixel |
| frame_start | output | 1 | One-cycle pulse after a frame-sync falling edge |

## Verification
Colour lines use pixels whose red, green and blue fields differ from each other and from pixel to pixel. This shows whether the RGB565 fields are packed in the right place and in the right byte order. Grayscale lines carry a chroma byte that is the complement of the luminance byte, so keeping the wrong byte of the pair, or leaking it into the high half of the output, shows up at once. A line that ends after an odd byte, followed by a normal line, checks that the pair phase restarts at each line. Bus toggling during blanking, and frames that begin after earlier lines, check the gating on `href` and the clearing of the counters on frame sync.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;
  localparam int CAM_BYTE_W = 8;
  localparam int CAM_PIX_W  = 2 * CAM_BYTE_W;

  // Colour: leading byte forms the upper half of the RGB565 word.
  function automatic logic [CAM_PIX_W-1:0] pack_rgb565(
    input logic [CAM_BYTE_W-1:0] lead,
    input logic [CAM_BYTE_W-1:0] trail
  );
    return {lead, trail};
  endfunction

  // Grayscale: leading byte of a YUYV pair is luminance, zero-extended.
  function automatic logic [CAM_PIX_W-1:0] gray_word(
    input logic [CAM_BYTE_W-1:0] luma
  );
    return {{CAM_BYTE_W{1'b0}}, luma};
  endfunction
endpackage

// File: rtl/cam_sync_edges.sv
module cam_sync_edges (
  input  logic pclk,
  input  logic rst_n,
  input  logic vsync,
  input  logic href,
  output logic vsync_fall,
  output logic href_rise
);
  logic vsync_q;
  logic href_q;

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      vsync_q <= 1'b0;
      href_q  <= 1'b0;
    end else begin
      vsync_q <= vsync;
      href_q  <= href;
    end
  end

  assign vsync_fall = vsync_q & ~vsync;
  assign href_rise  = ~href_q & href;

  // A line opening can never be seen on two edges in a row (R3)
  assert_rise_single_R3: assert property (@(posedge pclk) disable iff (!rst_n)
    href_rise |=> !href_rise);
endmodule

// File: rtl/cam_byte_pair.sv
module cam_byte_pair
  import cam_cap_pkg::*;
(
  input  logic                  pclk,
  input  logic                  rst_n,
  input  logic                  href,
  input  logic                  href_rise,
  input  logic [CAM_BYTE_W-1:0] din,
  input  logic                  gray_mode,
  output logic                  pair_done,
  output logic [CAM_PIX_W-1:0]  pix_data,
  output logic                  pix_valid
);
  logic                  phase_q;
  logic [CAM_BYTE_W-1:0] lead_q;
  logic                  take_lead;

  // Phase restarts at each line opening (R5)
  assign take_lead = href & (href_rise | ~phase_q);
  assign pair_done = href & ~href_rise & phase_q;

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= 1'b0;
      lead_q    <= '0;
      pix_data  <= '0;
      pix_valid <= 1'b0;
    end else begin
      phase_q   <= take_lead;
      pix_valid <= pair_done;
      if (take_lead) lead_q <= din;
      if (pair_done)
        pix_data <= gray_mode ? gray_word(lead_q) : pack_rgb565(lead_q, din);
    end
  end

  assert_valid_single_R8: assert property (@(posedge pclk) disable iff (!rst_n)
    pix_valid |=> !pix_valid);

  assert_valid_needs_href_R4: assert property (@(posedge pclk) disable iff (!rst_n)
    pix_valid |-> $past(href));

  assert_gray_upper_zero_R7: assert property (@(posedge pclk) disable iff (!rst_n)
    (pix_valid && $past(gray_mode)) |-> (pix_data[CAM_PIX_W-1:CAM_BYTE_W] == '0));
endmodule

// File: rtl/cam_position_counter.sv
module cam_position_counter #(
  parameter int COL_W  = 10,
  parameter int LINE_W = 9
) (
  input  logic              pclk,
  input  logic              rst_n,
  input  logic              vsync_fall,
  input  logic              href_rise,
  input  logic              pair_done,
  output logic [COL_W-1:0]  pix_col,
  output logic [LINE_W-1:0] pix_line,
  output logic              frame_start
);
  logic [COL_W-1:0] col_cnt;
  logic             line_seen;

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      col_cnt     <= '0;
      pix_col     <= '0;
      pix_line    <= '0;
      line_seen   <= 1'b0;
      frame_start <= 1'b0;
    end else if (vsync_fall) begin
      col_cnt     <= '0;
      pix_col     <= '0;
      pix_line    <= '0;
      line_seen   <= 1'b0;
      frame_start <= 1'b1;
    end else begin
      frame_start <= 1'b0;
      if (href_rise) begin
        col_cnt   <= '0;
        line_seen <= 1'b1;
        pix_line  <= line_seen ? pix_line + 1'b1 : '0;
      end else if (pair_done) begin
        pix_col <= col_cnt;
        col_cnt <= col_cnt + 1'b1;
      end
    end
  end

  assert_frame_clears_R2: assert property (@(posedge pclk) disable iff (!rst_n)
    frame_start |-> (pix_col == '0 && pix_line == '0));

  assert_first_col_zero_R9: assert property (@(posedge pclk) disable iff (!rst_n)
    (pair_done && $past(href_rise)) |=> (pix_col == '0));
endmodule

// File: rtl/cam_pixel_capture.sv
module cam_pixel_capture
  import cam_cap_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int LINE_W = 9
) (
  input  logic                  pclk,
  input  logic                  rst_n,
  input  logic                  vsync,
  input  logic                  href,
  input  logic [CAM_BYTE_W-1:0] din,
  input  logic                  gray_mode,
  output logic [CAM_PIX_W-1:0]  pix_data,
  output logic [COL_W-1:0]      pix_col,
  output logic [LINE_W-1:0]     pix_line,
  output logic                  pix_valid,
  output logic                  frame_start
);
  logic vsync_fall;
  logic href_rise;
  logic pair_done;

  cam_sync_edges u_edges (
    .pclk       (pclk),
    .rst_n      (rst_n),
    .vsync      (vsync),
    .href       (href),
    .vsync_fall (vsync_fall),
    .href_rise  (href_rise)
  );

  cam_byte_pair u_pair (
    .pclk      (pclk),
    .rst_n     (rst_n),
    .href      (href),
    .href_rise (href_rise),
    .din       (din),
    .gray_mode (gray_mode),
    .pair_done (pair_done),
    .pix_data  (pix_data),
    .pix_valid (pix_valid)
  );

  cam_position_counter #(.COL_W(COL_W), .LINE_W(LINE_W)) u_pos (
    .pclk        (pclk),
    .rst_n       (rst_n),
    .vsync_fall  (vsync_fall),
    .href_rise   (href_rise),
    .pair_done   (pair_done),
    .pix_col     (pix_col),
    .pix_line    (pix_line),
    .frame_start (frame_start)
  );

  // Frame start and a pixel strobe come from disjoint input events (R2, R8)
  assert_no_valid_at_frame_R2: assert property (@(posedge pclk) disable iff (!rst_n)
    frame_start |-> !pix_valid);
endmodule

// File: tb/tb_cam_pixel_capture.sv
`timescale 1ns/1ps
module tb_cam_pixel_capture;
  logic        pclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vsync = 1'b0;
  logic        href = 1'b0;
  logic [7:0]  din = 8'h00;
  logic        gray_mode = 1'b0;
  logic [15:0] pix_data;
  logic [9:0]  pix_col;
  logic [8:0]  pix_line;
  logic        pix_valid;
  logic        frame_start;

  int nvec = 0;
  int nbad = 0;

  always #4 pclk = ~pclk;

  cam_pixel_capture dut (
    .pclk(pclk), .rst_n(rst_n), .vsync(vsync), .href(href), .din(din),
    .gray_mode(gray_mode), .pix_data(pix_data), .pix_col(pix_col),
    .pix_line(pix_line), .pix_valid(pix_valid), .frame_start(frame_start)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
  endtask

  // Colour fields for a pixel
  function automatic logic [4:0] red_of(input int s, input int p);  return 5'((s * 7 + p * 3 + 1) & 31);  endfunction
  function automatic logic [5:0] grn_of(input int s, input int p);  return 6'((s * 11 + p * 5 + 9) & 63); endfunction
  function automatic logic [4:0] blu_of(input int s, input int p);  return 5'((s * 13 + p + 20) & 31);    endfunction
  function automatic logic [7:0] luma_of(input int s, input int p); return 8'((s * 17 + p * 29 + 3) & 255); endfunction

  function automatic logic [7:0] lead_byte(input bit g, input int s, input int p);
    logic [5:0] gg;
    gg = grn_of(s, p);
    return g ? luma_of(s, p) : {red_of(s, p), gg[5:3]};
  endfunction
  function automatic logic [7:0] trail_byte(input bit g, input int s, input int p);
    logic [5:0] gg;
    gg = grn_of(s, p);
    return g ? ~luma_of(s, p) : {gg[2:0], blu_of(s, p)};
  endfunction
  function automatic logic [15:0] expect_pix(input bit g, input int s, input int p);
    logic [15:0] w;
    w = 16'h0000;
    if (g) w[7:0] = luma_of(s, p);
    else begin
      w[15:11] = red_of(s, p);
      w[10:5]  = grn_of(s, p);
      w[4:0]   = blu_of(s, p);
    end
    return w;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge pclk);
    chk("R1 valid in reset", 32'(pix_valid), 0);
    chk("R1 frame_start in reset", 32'(frame_start), 0);
    chk("R1 data in reset", 32'(pix_data), 0);
    chk("R1 col/line in reset", {pix_col, pix_line}, 0);
    rst_n = 1'b1;
    @(negedge pclk);
    chk("R1 valid after release", 32'(pix_valid), 0);
  endtask

  task automatic t_frame();
    @(negedge pclk); href = 1'b0; vsync = 1'b1; din = 8'hA5;
    repeat (2) @(negedge pclk);
    vsync = 1'b0;
    @(negedge pclk);
    chk("R2 frame_start pulse", 32'(frame_start), 1);
    chk("R2 col cleared", 32'(pix_col), 0);
    chk("R2 line cleared", 32'(pix_line), 0);
    @(negedge pclk);
    chk("R2 frame_start one cycle", 32'(frame_start), 0);
  endtask

  // One line of npix pixels; optional stray trailing byte; then blanking
  task automatic send_line(input bit g, input int s, input int npix, input int line_idx, input bit odd_tail);
    gray_mode = g;
    @(negedge pclk); href = 1'b1; din = lead_byte(g, s, 0);
    for (int p = 0; p < npix; p++) begin
      @(negedge pclk);
      chk("R8 no valid after lead byte", 32'(pix_valid), 0);
      din = trail_byte(g, s, p);
      @(negedge pclk);
      chk("R8 valid after pair", 32'(pix_valid), 1);
      chk(g ? "R7 gray data" : "R6 colour data", 32'(pix_data), 32'(expect_pix(g, s, p)));
      chk("R9 column", 32'(pix_col), p);
      chk("R3 line", 32'(pix_line), line_idx);
      if (p < npix - 1) din = lead_byte(g, s, p + 1);
      else if (odd_tail) din = 8'h3C;
      else href = 1'b0;
    end
    if (odd_tail) begin
      @(negedge pclk);
      chk("R5 odd byte dropped", 32'(pix_valid), 0);
      href = 1'b0;
    end
    for (int k = 0; k < 3; k++) begin
      din = 8'(k * 85 + 7);
      @(negedge pclk);
      chk("R4 no valid while href low", 32'(pix_valid), 0);
      chk("R4 data held while href low", 32'(pix_data), 32'(expect_pix(g, s, npix - 1)));
    end
  endtask

  task automatic t_colour_frame();
    t_frame();
    for (int l = 0; l < 3; l++) send_line(1'b0, 10 + l, 4, l, 1'b0);
  endtask

  task automatic t_gray_frame();
    t_frame();
    for (int l = 0; l < 2; l++) send_line(1'b1, 40 + l, 5, l, 1'b0);
  endtask

  task automatic t_odd_tail();
    t_frame();
    send_line(1'b0, 60, 3, 0, 1'b1);
    send_line(1'b0, 61, 2, 1, 1'b0);
    send_line(1'b1, 62, 2, 2, 1'b1);
    send_line(1'b1, 63, 3, 3, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    nbad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_colour_frame();
    t_gray_frame();
    t_odd_tail();
    t_colour_frame();
    repeat (2) @(negedge pclk);
    summary();
    $finish;
  end
endmodule